// File: doc/BRIEF.md
# Timing Event Sequence Generator

This block drives the parallel side of a serial timing link. It sends one 16-bit word on every link clock. The high byte of each word is an event code and the low byte is a trigger or data byte. A host loads a small sequence table ahead of time. Each table entry pairs an 8-bit event code with a 16-bit cycle offset.

When a fiducial pulse arrives, the block walks the table from entry 0. It places each code on the link at its programmed offset from the fiducial. Every other cycle carries the null code 0x00. An end code in the table, or reaching the last table entry, stops the playback.

The host may change the table only between playbacks. A rejected write raises a one-cycle error flag. A fiducial that arrives during playback is not obeyed; it is counted in a saturating overrun counter. The serializer after this block, the line code and the optics are outside it.

Top module: `evseq_gen`

## Requirements
- R1: While reset is high, `link_word` is 0, `busy` is 0, `wr_err` is 0 and `ovr_cnt` is 0.
- R2: The low byte of `link_word` is always the value that `data_i` had on the previous clock edge.
- R3: While no playback runs, the high byte of `link_word` is 0x00.
- R4: If `fid_i` is high at an edge while `busy` is low, `busy` is high after that edge (edge E0). The entry whose turn comes at offset k places its code in the high byte of the word that appears after edge E0+k+1.
- R5: During playback, every word with no scheduled entry carries 0x00 in its high byte. The word after edge E0 is also null.
- R6: An entry whose offset is not larger than the cycle used by the entry before it goes out in the cycle after that entry.
- R7: An entry with code 0x7F sends nothing and ends playback. `busy` falls on the edge one cycle after the previous entry's cycle, or on edge E0+1 if the 0x7F entry is entry 0.
- R8: A write with `wr_en` high while `busy` is high leaves the table unchanged. `wr_err` is high for exactly the one cycle after that edge. A write while idle does not raise `wr_err`.
- R9: A high `fid_i` while `busy` is high does not restart playback. It adds 1 to `ovr_cnt`, which holds at its maximum (255 by default).
- R10: If the last table entry is an ordinary code, it is sent and `busy` falls on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link word clock |
| rst | input | 1 | Synchronous reset, active high |
| fid_i | input | 1 | Fiducial pulse that starts playback |
| data_i | input | 8 | Data byte for the low half of the next word |
| wr_en | input | 1 | Host table write strobe |
| wr_addr | input | 4 | Table entry index to write |
| wr_code | input | 8 | Event code to store |
| wr_ofs | input | 16 | Cycle offset to store |
| link_word | output | 16 | Word for the serializer: code in the high byte, data in the low byte |
| busy | output | 1 | Playback in progress |
| wr_err | output | 1 | One-cycle flag for a rejected write |
| ovr_cnt | output | 8 | Saturating count of fiducials that were not obeyed |

## Verification
Random tables are played with offsets that mostly rise. Some offsets are deliberately equal or smaller than the one before, so an in-order schedule can be told apart from one that stalls on a missed offset. Directed tables cover:
- a leading end code, which separates ending on the marker from ending by table exhaustion;
- a full table with no end code, which checks that the last entry is still sent;
- a write and a fiducial injected mid-playback, which are then replayed to show that the table and the schedule were untouched.

A long playback with the fiducial held high checks that the overrun counter stops at its maximum.

// File: rtl/evseq_pkg.sv
package evseq_pkg;

    localparam int CODE_W = 8;
    localparam int OFS_W  = 16;
    localparam int DATA_W = 8;
    localparam int WORD_W = CODE_W + DATA_W;

    localparam logic [CODE_W-1:0] CODE_NULL = 8'h00;
    localparam logic [CODE_W-1:0] CODE_STOP = 8'h7F;

    typedef struct packed {
        logic [OFS_W-1:0]  ofs;
        logic [CODE_W-1:0] code;
    } ent_t;

    typedef enum logic {ST_IDLE, ST_PLAY} st_t;

    function automatic logic is_stop(input logic [CODE_W-1:0] c);
        return c == CODE_STOP;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input logic [CODE_W-1:0] c,
                                                    input logic [DATA_W-1:0] d);
        return {c, d};
    endfunction

endpackage

// File: rtl/evseq_table.sv
module evseq_table
    import evseq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  ent_t          wdata,
    input  logic [AW-1:0] raddr,
    output ent_t          rdata
);

    ent_t mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (we && waddr == AW'(g)) begin
                mem[g] <= wdata;
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/evseq_player.sv
module evseq_player
    import evseq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fid_i,
    input  logic [DATA_W-1:0] data_i,
    input  ent_t              rd_ent,
    output logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] link_word,
    output logic              busy
);

    localparam logic [AW-1:0]    LAST  = AW'(DEPTH - 1);
    localparam logic [OFS_W-1:0] T_MAX = '1;

    st_t              st;
    logic [AW-1:0]    ptr;
    logic [OFS_W-1:0] tcnt;
    logic             due;

    assign due     = rd_ent.ofs <= tcnt;
    assign rd_addr = ptr;
    assign busy    = st == ST_PLAY;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            ptr       <= '0;
            tcnt      <= '0;
            link_word <= '0;
        end else begin
            link_word <= pack_word(CODE_NULL, data_i);
            unique case (st)
                ST_IDLE: begin
                    if (fid_i) begin
                        st   <= ST_PLAY;
                        ptr  <= '0;
                        tcnt <= '0;
                    end
                end
                ST_PLAY: begin
                    if (is_stop(rd_ent.code)) begin
                        st <= ST_IDLE;
                    end else if (due) begin
                        link_word <= pack_word(rd_ent.code, data_i);
                        if (ptr == LAST) begin
                            st <= ST_IDLE;
                        end else begin
                            ptr <= ptr + 1'b1;
                        end
                    end
                    if (tcnt != T_MAX) begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/evseq_guard.sv
module evseq_guard #(
    parameter int OVR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy,
    input  logic             fid_i,
    input  logic             wr_en,
    output logic             ram_we,
    output logic             wr_err,
    output logic [OVR_W-1:0] ovr_cnt
);

    localparam logic [OVR_W-1:0] OVR_MAX = '1;

    assign ram_we = wr_en && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_err  <= 1'b0;
            ovr_cnt <= '0;
        end else begin
            wr_err <= wr_en && busy;
            if (fid_i && busy && ovr_cnt != OVR_MAX) begin
                ovr_cnt <= ovr_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/evseq_gen.sv
module evseq_gen
    import evseq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int OVR_W = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fid_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [OFS_W-1:0]  wr_ofs,
    output logic [WORD_W-1:0] link_word,
    output logic              busy,
    output logic              wr_err,
    output logic [OVR_W-1:0]  ovr_cnt
);

    ent_t          wr_ent;
    ent_t          rd_ent;
    logic [AW-1:0] rd_addr;
    logic          ram_we;

    assign wr_ent = '{ofs: wr_ofs, code: wr_code};

    evseq_guard #(.OVR_W(OVR_W)) u_guard (
        .clk     (clk),
        .rst     (rst),
        .busy    (busy),
        .fid_i   (fid_i),
        .wr_en   (wr_en),
        .ram_we  (ram_we),
        .wr_err  (wr_err),
        .ovr_cnt (ovr_cnt)
    );

    evseq_table #(.DEPTH(DEPTH), .AW(AW)) u_table (
        .clk   (clk),
        .we    (ram_we),
        .waddr (wr_addr),
        .wdata (wr_ent),
        .raddr (rd_addr),
        .rdata (rd_ent)
    );

    evseq_player #(.DEPTH(DEPTH), .AW(AW)) u_player (
        .clk       (clk),
        .rst       (rst),
        .fid_i     (fid_i),
        .data_i    (data_i),
        .rd_ent    (rd_ent),
        .rd_addr   (rd_addr),
        .link_word (link_word),
        .busy      (busy)
    );

endmodule

// File: rtl/evseq_gen_chk.sv
module evseq_gen_chk #(
    parameter int OVR_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             fid_i,
    input logic [7:0]       data_i,
    input logic             wr_en,
    input logic [15:0]      link_word,
    input logic             busy,
    input logic             wr_err,
    input logic [OVR_W-1:0] ovr_cnt
);

    localparam logic [OVR_W-1:0] OVR_MAX = '1;

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (link_word == 16'h0 && !busy && !wr_err && ovr_cnt == '0));

    a_r2_data_byte: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> link_word[7:0] == $past(data_i));

    a_r3_idle_null: assert property (@(posedge clk) disable iff (rst)
        (!busy && !fid_i) |=> link_word[15:8] == 8'h00);

    a_r4_start: assert property (@(posedge clk) disable iff (rst)
        (!busy && fid_i) |=> (busy && link_word[15:8] == 8'h00));

    a_r8_err_cause: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> $past(busy && wr_en));

    a_r8_idle_write_ok: assert property (@(posedge clk) disable iff (rst)
        (!busy && wr_en) |=> !wr_err);

    a_r9_overrun_inc: assert property (@(posedge clk) disable iff (rst)
        (busy && fid_i && ovr_cnt != OVR_MAX) |=> ovr_cnt == $past(ovr_cnt) + 1'b1);

    a_r9_overrun_hold: assert property (@(posedge clk) disable iff (rst)
        !(busy && fid_i) |=> $stable(ovr_cnt));

    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && fid_i && ovr_cnt == OVR_MAX) |=> ovr_cnt == OVR_MAX);

endmodule

bind evseq_gen evseq_gen_chk #(.OVR_W(OVR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fid_i     (fid_i),
    .data_i    (data_i),
    .wr_en     (wr_en),
    .link_word (link_word),
    .busy      (busy),
    .wr_err    (wr_err),
    .ovr_cnt   (ovr_cnt)
);

// File: tb/sim_evseq_gen.sv
`timescale 1ns/1ps
module sim_evseq_gen;

    localparam int D  = 16;
    localparam int AW = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fid = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  din = 8'h00;
    logic [7:0]  wcode = 8'h00;
    logic [AW-1:0] waddr = '0;
    logic [15:0] wofs = 16'h0;
    logic [15:0] link_word;
    logic        busy;
    logic        wr_err;
    logic [7:0]  ovr_cnt;

    int total = 0;
    int bad   = 0;
    bit finished = 0;
    logic [7:0] last_d;

    int m_code [D];
    int m_ofs  [D];
    int exp_c  [1024];
    int t_end;

    always #2.5 clk = ~clk;

    evseq_gen u0 (
        .clk(clk), .rst(rst), .fid_i(fid), .data_i(din),
        .wr_en(wr_en), .wr_addr(waddr), .wr_code(wcode), .wr_ofs(wofs),
        .link_word(link_word), .busy(busy), .wr_err(wr_err), .ovr_cnt(ovr_cnt)
    );

    task automatic chk(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic tick();
        last_d = din;
        @(posedge clk);
        @(negedge clk);
        chk("R2 data byte", int'(link_word[7:0]), int'(last_d));
        din = 8'($urandom);
    endtask

    task automatic put(input int addr, input int code, input int ofs);
        waddr = AW'(addr); wcode = 8'(code); wofs = 16'(ofs); wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
        m_code[addr] = code; m_ofs[addr] = ofs;
        chk("R8 idle write raises no flag", int'(wr_err), 0);
    endtask

    function automatic void build();
        int tp = -1;
        bit done = 0;
        foreach (exp_c[i]) exp_c[i] = 0;
        t_end = 0;
        for (int i = 0; i < D; i++) begin
            if (!done) begin
                if (m_code[i] == 8'h7F) begin
                    t_end = tp + 1;
                    done = 1;
                end else begin
                    int t = (m_ofs[i] > tp + 1) ? m_ofs[i] : tp + 1;
                    exp_c[t] = m_code[i];
                    tp = t;
                    if (i == D - 1) t_end = tp;
                end
            end
        end
    endfunction

    task automatic play(input string tag, input bit inj);
        int ov0;
        build();
        ov0 = int'(ovr_cnt);
        fid = 1'b1;
        tick();
        fid = 1'b0;
        chk("R4 busy after fiducial", int'(busy), 1);
        chk("R5 null word at start", int'(link_word[15:8]), 0);
        for (int j = 1; j <= t_end + 1; j++) begin
            if (inj && j == 2) begin
                waddr = '0; wcode = 8'h55; wofs = 16'h0; wr_en = 1'b1;
            end
            if (inj && j == 3) fid = 1'b1;
            tick();
            wr_en = 1'b0;
            fid = 1'b0;
            chk(tag, int'(link_word[15:8]), exp_c[j-1]);
            chk("R7 busy window", int'(busy), (j <= t_end) ? 1 : 0);
            if (inj && j == 2) chk("R8 error flag on busy write", int'(wr_err), 1);
            if (inj && j == 3) begin
                chk("R8 error flag lasts one cycle", int'(wr_err), 0);
                chk("R9 overrun counted", int'(ovr_cnt), (ov0 + 1 > 255) ? 255 : ov0 + 1);
            end
        end
        tick();
        chk("R3 idle word null", int'(link_word[15:8]), 0);
        chk("R3 idle after end", int'(busy), 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 word in reset", int'(link_word), 0);
        chk("R1 busy in reset", int'(busy), 0);
        chk("R1 overrun in reset", int'(ovr_cnt), 0);
        chk("R1 error in reset", int'(wr_err), 0);
        rst = 1'b0;
        tick();
        chk("R3 null after reset", int'(link_word[15:8]), 0);

        // R7: end code at entry 0
        for (int i = 0; i < D; i++) put(i, 8'h7F, 0);
        play("R7 leading end code", 1'b0);

        // R10: full table, no end code
        for (int i = 0; i < D; i++) put(i, 8'h10 + i, 3 * i + 2);
        play("R10 full table", 1'b0);

        // R6: non-increasing offsets
        put(0, 8'h21, 5); put(1, 8'h22, 5); put(2, 8'h23, 1);
        put(3, 8'h24, 20); put(4, 8'h7F, 0);
        play("R6 late entries", 1'b0);

        // R8/R9: write and fiducial during playback, then replay
        put(0, 8'h31, 2); put(1, 8'h32, 6); put(2, 8'h33, 9); put(3, 8'h7F, 0);
        play("R4 scheduled code", 1'b1);
        play("R8 table unchanged", 1'b0);

        // random tables
        for (int r = 0; r < 14; r++) begin
            int n = int'($urandom % (D + 1));
            int prev = 0;
            for (int i = 0; i < D; i++) begin
                if (i < n) begin
                    int o = ($urandom % 4 == 0) ? int'($urandom % (prev + 1))
                                                : prev + int'($urandom % 6);
                    int c;
                    do c = int'($urandom % 256); while (c == 8'h7F);
                    put(i, c, o);
                    prev = o;
                end else if (i == n) begin
                    put(i, 8'h7F, int'($urandom % 50));
                end
            end
            play("R5 random schedule", 1'b0);
        end

        // R9: saturation of overrun counter
        put(0, 8'h44, 400); put(1, 8'h7F, 0);
        fid = 1'b1;
        tick();
        for (int k = 0; k < 300; k++) tick();
        fid = 1'b0;
        chk("R9 overrun saturates", int'(ovr_cnt), 255);
        chk("R9 no restart", int'(busy), 1);
        for (int k = 0; k < 500 && busy; k++) tick();
        chk("R7 playback ended", int'(busy), 0);
        tick();
        chk("R3 idle null at end", int'(link_word[15:8]), 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule